// File: doc/BRIEF.md
# Indirect Mailbox Register Bridge

This block gives software access to a small bank of 8-bit configuration registers through one 32-bit control word. The bank holds the mixer, volume and amplifier settings of an audio path. Software does not address each register directly. It packs a register index and a value into fields of the control word, and it raises a strobe bit to commit the value. It reads the selected register back from the low byte of the same word.

The host side is a simple single-cycle port. A write enable loads the writable fields of the word on the clock edge. The read data is always present. A release bit in the word gates the whole bank: while that bit is clear, every register stays at zero and commits have no effect. Register 0 drives the headphone volume and the amplifier clock-gate enable straight out of the block.

Top module: `mbx_reg_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, the word and every bank register are cleared. After reset `host_rdata` reads 0x00000000 and register 0 outputs are zero.
- R2: The release bit (28), strobe bit (24), index field (20:16) and value field (15:8) read back as last written. Bits 31:29, 27:25 and 23:21 always read 0. A host write to bits 7:0 has no effect.
- R3: A 0-to-1 change of bit 24 writes the value field into the register selected by the index field. The new contents read back one cycle after the host write that raised the strobe.
- R4: Exactly one commit happens per rising strobe. Later host writes that keep bit 24 at 1 do not write the register, even when they change the value field.
- R5: While bit 28 is 0, all registers hold zero and a rising strobe writes nothing. Clearing bit 28 after writes returns every register to zero on the next edge.
- R6: Valid indices run from 0 to 24. For an index of 25 to 31, bits 7:0 read 0x00 and a commit changes no register.
- R7: Register 0 bit 6 is reserved and always reads 0. Bits 5:0 drive `hp_volume` and bit 7 drives `hp_clk_gate`.
- R8: Bits 7:0 follow the bank through combinational logic. They show the contents of the newly selected register in the same cycle that a host write changes the index field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Load the control word from `host_wdata` on this edge |
| host_wdata | input | 32 | Control word value written by the host |
| host_rdata | output | 32 | Current control word with the selected register in bits 7:0 |
| hp_volume | output | 6 | Headphone volume taken from register 0 |
| hp_clk_gate | output | 1 | Amplifier clock-gate enable taken from register 0 |

## Verification
A wrong value in the bank shows up at bits 7:0 as soon as software selects that register. The sweep therefore reads every index after every write phase and compares the result with a scoreboard. A fault in strobe detection shows one cycle after a host write: a second write can land while the strobe stays high, or the expected write can be missing. Both cases are checked at the next readback. A fault in the release gating or the index range shows as nonzero data after a cleared release bit, or as an out-of-range write that lands in another register. A full readback pass after each such step catches it.

// File: rtl/mbx_pkg.sv
// Package: field positions of the host control word and bank constants.
// Assumes an 8-bit register width; the index field is five bits wide.
package mbx_pkg;
    localparam int WORD_W      = 32;
    localparam int DATA_W      = 8;
    localparam int IDX_W       = 5;
    localparam int BIT_RELEASE = 28;
    localparam int BIT_STROBE  = 24;
    localparam int IDX_LSB     = 16;
    localparam int DIN_LSB     = 8;
    localparam int DOUT_LSB    = 0;

    // Writable-bit mask per register: register 0 bit 6 is reserved.
    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        return (idx == 0) ? 8'hBF : 8'hFF;
    endfunction
endpackage

// File: rtl/mbx_host_word.sv
// Module: mbx_host_word
// Holds the host-writable fields of the control word and turns a rising
// strobe bit into a one-cycle commit pulse.
// Assumes the host writes the whole word at once through host_we.
module mbx_host_word
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              release_q,
    output logic              strobe_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic [DATA_W-1:0] din_q,
    output logic              commit
);
    logic strobe_prev;

    // These bits of the host word are not stored.
    logic unused_bits;
    assign unused_bits = ^{host_wdata[31:29], host_wdata[27:25],
                           host_wdata[23:21], host_wdata[7:0]};

    // Load the writable fields on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            release_q <= 1'b0;
            strobe_q  <= 1'b0;
            idx_q     <= '0;
            din_q     <= '0;
        end else if (host_we) begin
            release_q <= host_wdata[BIT_RELEASE];
            strobe_q  <= host_wdata[BIT_STROBE];
            idx_q     <= host_wdata[IDX_LSB +: IDX_W];
            din_q     <= host_wdata[DIN_LSB +: DATA_W];
        end
    end

    // Keep the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev <= 1'b0;
        else        strobe_prev <= strobe_q;
    end

    // The commit pulse is high only in the first cycle of a new strobe level.
    assign commit = strobe_q & ~strobe_prev;

    // R4: a commit pulse never lasts more than one cycle.
    p_single_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !host_we |=> !commit);

    // R2: a host write is reflected in the stored strobe on the next cycle.
    p_strobe_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> strobe_q == $past(host_wdata[BIT_STROBE]));
endmodule

// File: rtl/mbx_reg_bank.sv
// Module: mbx_reg_bank
// Bank of NUM_REGS 8-bit registers. A register takes the value on a commit
// while the bank is released. A cleared release bit holds the whole bank at
// zero. Readback is combinational and returns zero for an index out of range.
// Assumes NUM_REGS <= 2**IDX_W.
module mbx_reg_bank
    import mbx_pkg::*;
#(
    parameter int NUM_REGS = 25
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       release_q,
    input  logic                       commit,
    input  logic [IDX_W-1:0]           idx,
    input  logic [DATA_W-1:0]          din,
    output logic [DATA_W-1:0]          dout,
    output logic [NUM_REGS*DATA_W-1:0] bank_flat
);
    localparam int BANK_BITS = NUM_REGS * DATA_W;

    logic [DATA_W-1:0] regs [NUM_REGS];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            localparam logic [DATA_W-1:0] MASK = reg_mask(gi);
            // Clear, hold or take the committed value for one register.
            always_ff @(posedge clk) begin
                if (!rst_n || !release_q)
                    regs[gi] <= '0;
                else if (commit && (int'(idx) == gi))
                    regs[gi] <= din & MASK;
            end
            assign bank_flat[gi*DATA_W +: DATA_W] = regs[gi];

            // R3: a commit to this index lands the masked value.
            p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
                commit && release_q && (int'(idx) == gi)
                |=> regs[gi] == ($past(din) & MASK));
        end
    endgenerate

    // Select the register named by the index field, or zero outside the bank.
    always_comb begin
        dout = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (int'(idx) == k) dout = regs[k];
        end
    end

    // R5: a cleared release bit leaves the bank all zero.
    p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !release_q |=> bank_flat == '0);

    // R6: a commit to an index outside the bank changes nothing.
    p_oob_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit && release_q && (int'(idx) >= NUM_REGS) |=> $stable(bank_flat));

    // R6: readback outside the bank is zero.
    p_oob_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx) >= NUM_REGS |-> dout == '0);

    // R4: without a commit the bank only stays put or clears.
    p_no_stray_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit && release_q |=> $stable(bank_flat) || !release_q);

    logic unused_bank;
    assign unused_bank = ^BANK_BITS;
endmodule

// File: rtl/mbx_reg_bridge.sv
// Module: mbx_reg_bridge (top)
// Places the host word fields at fixed bit positions, feeds the bank and
// assembles the read word. Register 0 drives the headphone outputs.
// Assumes a single-cycle host port with the read data always valid.
module mbx_reg_bridge
    import mbx_pkg::*;
#(
    parameter int NUM_REGS = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic [5:0]  hp_volume,
    output logic        hp_clk_gate
);
    logic                       release_q;
    logic                       strobe_q;
    logic [IDX_W-1:0]           idx_q;
    logic [DATA_W-1:0]          din_q;
    logic                       commit;
    logic [DATA_W-1:0]          dout;
    logic [NUM_REGS*DATA_W-1:0] bank_flat;

    mbx_host_word u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .release_q  (release_q),
        .strobe_q   (strobe_q),
        .idx_q      (idx_q),
        .din_q      (din_q),
        .commit     (commit)
    );

    mbx_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_q (release_q),
        .commit    (commit),
        .idx       (idx_q),
        .din       (din_q),
        .dout      (dout),
        .bank_flat (bank_flat)
    );

    // Build the read word; the bits without a field read as zero.
    always_comb begin
        host_rdata                         = '0;
        host_rdata[BIT_RELEASE]            = release_q;
        host_rdata[BIT_STROBE]             = strobe_q;
        host_rdata[IDX_LSB +: IDX_W]       = idx_q;
        host_rdata[DIN_LSB +: DATA_W]      = din_q;
        host_rdata[DOUT_LSB +: DATA_W]     = dout;
    end

    // Register 0 fields drive the headphone outputs.
    assign hp_volume   = bank_flat[5:0];
    assign hp_clk_gate = bank_flat[7];

    // R2: the bits without a field read zero.
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[31:29] == 3'b0 && host_rdata[27:25] == 3'b0 &&
        host_rdata[23:21] == 3'b0);

    // R7: the reserved bit of register 0 never reads as one.
    p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q == '0 |-> host_rdata[6] == 1'b0);

    // R1: the cycle after reset, the word reads all zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> host_rdata == 32'h0);
endmodule

// File: tb/mbx_reg_bridge_test.sv
// Bench: software-style sequences against a scoreboard of the bank.
module mbx_reg_bridge_test;
    localparam int NREG = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [5:0]  hp_volume;
    logic        hp_clk_gate;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0]  sb [32];
    logic [31:0] shadow = '0;

    mbx_reg_bridge #(.NUM_REGS(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .hp_volume(hp_volume), .hp_clk_gate(hp_clk_gate)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        host_we = 1'b1;
        host_wdata = w;
        shadow = w;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic logic [31:0] expected_word(input logic [31:0] w);
        logic [31:0] e;
        e = w & 32'h111F_FF00;
        e[7:0] = sb[w[20:16]];
        return e;
    endfunction

    task automatic sw_write(input int idx, input logic [7:0] val);
        logic [31:0] w;
        w = shadow;
        w[20:16] = idx[4:0];
        w[15:8] = val;
        w[24] = 1'b0;
        host_write(w);
        w[24] = 1'b1;
        host_write(w);
        w[24] = 1'b0;
        host_write(w);
        if (shadow[28] && idx < NREG)
            sb[idx] = (idx == 0) ? (val & 8'hBF) : val;
    endtask

    task automatic sw_read_all(input string req);
        for (int i = 0; i < 32; i++) begin
            logic [31:0] w;
            w = shadow;
            w[20:16] = i[4:0];
            host_write(w);
            check(req, host_rdata, expected_word(w));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) sb[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: state after reset.
        check("R1", host_rdata, 32'h0);
        check("R1", {25'b0, hp_clk_gate, hp_volume}, 32'h0);
        rst_n = 1'b1;

        // R2: field readback, unused bits zero, bits 7:0 ignored.
        host_write(32'hEEE5_A7FF);
        check("R2", host_rdata, 32'h0005_A700);
        host_write(32'h1000_0000);

        // R5: held bank ignores strobes.
        host_write(32'h0000_0000);
        sw_write(3, 8'h5A);
        sw_read_all("R5");

        // R3 R6 R7: full sweep of writes, then readback of every index.
        host_write(32'h1000_0000);
        for (int i = 0; i < 32; i++) sw_write(i, 8'((i * 37 + 5) ^ 8'hC3));
        sw_read_all("R3");
        sw_write(0, 8'hFF);
        host_write(32'h1000_0000);
        check("R7", host_rdata[7:0], 8'hBF);
        check("R7", {hp_clk_gate, hp_volume}, 7'h7F);
        sw_write(0, 8'h6A);
        check("R7", {hp_clk_gate, hp_volume}, 7'h2A);

        // R6: out-of-range writes leave the bank unchanged.
        for (int i = NREG; i < 32; i++) sw_write(i, 8'hA5);
        sw_read_all("R6");

        // R4: strobe held high, value changed, no second write.
        sw_write(9, 8'h11);
        host_write(32'h1109_2200);
        host_write(32'h1109_3300);
        sb[9] = 8'h22;
        check("R4", host_rdata[7:0], 8'h22);
        host_write(32'h1109_4400);
        check("R4", host_rdata[7:0], 8'h22);
        host_write(32'h1009_4400);
        sw_read_all("R4");

        // R8: index change is seen in the same cycle as the word update.
        sw_write(12, 8'h3C);
        host_write(32'h100C_0000);
        check("R8", host_rdata[7:0], 8'h3C);
        host_write(32'h1009_0000);
        check("R8", host_rdata[7:0], 8'h22);

        // R5: clearing the release bit zeroes the bank.
        host_write(32'h0000_0000);
        for (int i = 0; i < 32; i++) sb[i] = 8'h00;
        sw_read_all("R5");
        check("R5", {25'b0, hp_clk_gate, hp_volume}, 32'h0);

        // R1: reset in mid-run clears the word and the bank.
        host_write(32'h1000_0000);
        sw_write(1, 8'h77);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1", host_rdata, 32'h0);
        shadow = 32'h0;
        for (int i = 0; i < 32; i++) sb[i] = 8'h00;
        host_write(32'h1001_0000);
        check("R1", host_rdata[7:0], 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule